// File: doc/BRIEF.md
# Spare-Area Bad Block Scanner

This block decides whether one erase block of a NAND array carries a factory bad-block mark. A caller pulses `start_i` with a block number, the number of pages in a block, the index of the page that holds the mark and the spare-area byte offset of the mark. The scanner then asks a downstream NAND command sequencer for single spare-area bytes, one request at a time. Each request carries a full page (row) address and a spare-area column. The scanner compares every byte that comes back with the erased value 0xFF.

There are two ways to scan. If the mark page index is a real page of the block, one byte is read and checked. If the mark page index is at or beyond the end of the block, the scanner checks four pages: the first two and the last two. On each of those pages it reads spare bytes 0 and 1. The first byte that is not 0xFF ends the scan at once, with the block reported bad. The result is given as a one-cycle `done_o` pulse, and `bad_o` holds its value until the next result.

Top module: `badblk_scan`

## Requirements
- R1: When `mark_page_i >= ppb_i` at start, the scan runs in four-page mode. Otherwise it runs in single-byte mode. A good block gives exactly 8 requests in four-page mode and exactly 1 in single-byte mode.
- R2: In four-page mode the requests come in this order: page offsets 0, 1, ppb-2, ppb-1. Each page is read at column 0 first and then at column 1. `req_col_o` is always 0 or 1 in this mode.
- R3: In single-byte mode the one request is for page offset `mark_page_i` at column `mark_pos_i`.
- R4: `req_page_o` equals `blk_i * ppb_i + offset`, using the values captured at start.
- R5: `bad_o` is 1 at the done pulse if any checked byte differs from 0xFF. It is 0 if every checked byte is 0xFF. A non-0xFF byte at a location that is not checked has no effect.
- R6: After the first non-0xFF response, no further requests are issued. `req_valid_o` is low whenever `busy_o` is low.
- R7: A `start_i` pulse while `busy_o` is high is ignored. The scan in progress keeps its captured parameters, and a second done pulse does not occur.
- R8: `done_o` is high for exactly one cycle per scan. `bad_o` changes only in a cycle where `done_o` is high.
- R9: While `req_valid_o` is high and `req_ready_i` is low, the request stays valid with the same page and column.
- R10: After reset, `busy_o`, `req_valid_o`, `done_o` and `bad_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a scan; ignored while busy |
| blk_i | input | BLK_W | Erase block number |
| ppb_i | input | PPB_W | Pages per block (at least 2) |
| mark_page_i | input | PPB_W | Page offset of the mark; a value >= ppb_i selects four-page mode |
| mark_pos_i | input | COL_W | Spare-area byte offset of the mark in single-byte mode |
| req_valid_o | output | 1 | Spare byte read request is valid |
| req_ready_i | input | 1 | Sequencer accepts the request |
| req_page_o | output | BLK_W+PPB_W | Row (page) address of the request |
| req_col_o | output | COL_W | Spare-area byte offset of the request |
| rsp_valid_i | input | 1 | Read byte is valid |
| rsp_data_i | input | 8 | Read byte |
| busy_o | output | 1 | Scan in progress |
| done_o | output | 1 | One-cycle result strobe |
| bad_o | output | 1 | Block is marked bad (held until the next result) |

## Verification
The bench builds the block with its default widths: a 10-bit block number and 8-bit page counts. Block sizes from 4 to 255 pages then multiply out to row addresses that reach the top of the 18-bit address space, so the multiplier's upper bits are tested. The 8-bit page index also lets the bench put the mark page exactly at `ppb_i` and at `ppb_i - 1`, which is the edge between the two modes. In four-page mode it can place a single bad byte at each of the eight checked positions in turn. The bench also varies the ready and response latency at random, so the request-hold and early-stop behaviour are tested across different handshake timings.

// File: rtl/badblk_pkg.sv
package badblk_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } scan_state_e;

    localparam int          STEP_W      = 3;
    localparam int          QUAD_STEPS  = 8;
    localparam logic [7:0]  ERASED_BYTE = 8'hFF;

endpackage

// File: rtl/badblk_plan.sv
// Maps the step index of a scan onto the page offset and spare column to read.
module badblk_plan
    import badblk_pkg::*;
#(
    parameter int PPB_W = 8,
    parameter int COL_W = 8
) (
    input  logic              four_i,
    input  logic [STEP_W-1:0] step_i,
    input  logic [PPB_W-1:0]  ppb_i,
    input  logic [PPB_W-1:0]  mark_page_i,
    input  logic [COL_W-1:0]  mark_pos_i,
    output logic [PPB_W-1:0]  off_o,
    output logic [COL_W-1:0]  col_o,
    output logic              last_o
);

    localparam logic [PPB_W-1:0] ONE_P = PPB_W'(1);
    localparam logic [PPB_W-1:0] TWO_P = PPB_W'(2);

    logic [PPB_W-1:0] quad_off;

    always_comb begin
        unique case (step_i[2:1])
            2'd0:    quad_off = '0;
            2'd1:    quad_off = ONE_P;
            2'd2:    quad_off = ppb_i - TWO_P;
            default: quad_off = ppb_i - ONE_P;
        endcase
    end

    always_comb begin
        if (four_i) begin
            off_o  = quad_off;
            col_o  = COL_W'(step_i[0]);
            last_o = (step_i == STEP_W'(QUAD_STEPS - 1));
        end else begin
            off_o  = mark_page_i;
            col_o  = mark_pos_i;
            last_o = 1'b1;
        end
    end

endmodule

// File: rtl/badblk_addr.sv
// Row address of the page being checked: block * pages-per-block + offset.
module badblk_addr #(
    parameter int BLK_W = 10,
    parameter int PPB_W = 8,
    localparam int ROW_W = BLK_W + PPB_W
) (
    input  logic [BLK_W-1:0] blk_i,
    input  logic [PPB_W-1:0] ppb_i,
    input  logic [PPB_W-1:0] off_i,
    output logic [ROW_W-1:0] row_o
);

    logic [ROW_W-1:0] base;

    always_comb begin
        base  = ROW_W'(blk_i) * ROW_W'(ppb_i);
        row_o = base + ROW_W'(off_i);
    end

endmodule

// File: rtl/badblk_ctrl.sv
// Scan control: captures parameters, walks the steps, compares bytes, reports.
module badblk_ctrl
    import badblk_pkg::*;
#(
    parameter int BLK_W = 10,
    parameter int PPB_W = 8,
    parameter int COL_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [BLK_W-1:0]  blk_i,
    input  logic [PPB_W-1:0]  ppb_i,
    input  logic [PPB_W-1:0]  mark_page_i,
    input  logic [COL_W-1:0]  mark_pos_i,
    input  logic              req_ready_i,
    input  logic              rsp_valid_i,
    input  logic [7:0]        rsp_data_i,
    input  logic              last_i,
    output logic [BLK_W-1:0]  blk_o,
    output logic [PPB_W-1:0]  ppb_o,
    output logic [PPB_W-1:0]  mark_page_o,
    output logic [COL_W-1:0]  mark_pos_o,
    output logic              four_o,
    output logic [STEP_W-1:0] step_o,
    output logic              req_valid_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              bad_o
);

    typedef struct packed {
        scan_state_e       state;
        logic [BLK_W-1:0]  blk;
        logic [PPB_W-1:0]  ppb;
        logic [PPB_W-1:0]  mpage;
        logic [COL_W-1:0]  mpos;
        logic              four;
        logic [STEP_W-1:0] step;
        logic              done;
        logic              bad;
    } scan_regs_t;

    scan_regs_t regs_d, regs_q;
    logic       mismatch;

    always_comb begin
        regs_d      = regs_q;
        regs_d.done = 1'b0;
        mismatch    = (rsp_data_i != ERASED_BYTE);
        unique case (regs_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    regs_d.blk   = blk_i;
                    regs_d.ppb   = ppb_i;
                    regs_d.mpage = mark_page_i;
                    regs_d.mpos  = mark_pos_i;
                    regs_d.four  = (mark_page_i >= ppb_i);
                    regs_d.step  = '0;
                    regs_d.state = ST_ISSUE;
                end
            end
            ST_ISSUE: begin
                if (req_ready_i) begin
                    regs_d.state = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (rsp_valid_i) begin
                    if (mismatch || last_i) begin
                        regs_d.state = ST_IDLE;
                        regs_d.done  = 1'b1;
                        regs_d.bad   = mismatch;
                    end else begin
                        regs_d.step  = regs_q.step + STEP_W'(1);
                        regs_d.state = ST_ISSUE;
                    end
                end
            end
            default: regs_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '{state: ST_IDLE, default: '0};
        end else begin
            regs_q <= regs_d;
        end
    end

    assign blk_o       = regs_q.blk;
    assign ppb_o       = regs_q.ppb;
    assign mark_page_o = regs_q.mpage;
    assign mark_pos_o  = regs_q.mpos;
    assign four_o      = regs_q.four;
    assign step_o      = regs_q.step;
    assign req_valid_o = (regs_q.state == ST_ISSUE);
    assign busy_o      = (regs_q.state != ST_IDLE);
    assign done_o      = regs_q.done;
    assign bad_o       = regs_q.bad;

    // R8: the result strobe never lasts two cycles
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R8: the verdict only moves together with the strobe
    assert_bad_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(bad_o));

    // R7: a scan only begins from a start seen while idle
    assert_start_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(start_i) && !$past(busy_o));

    // R8: the strobe marks the return to idle
    assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

endmodule

// File: rtl/badblk_scan.sv
// Top: bad block mark scanner over a spare-byte request/response link.
module badblk_scan
    import badblk_pkg::*;
#(
    parameter int BLK_W = 10,
    parameter int PPB_W = 8,
    parameter int COL_W = 8,
    localparam int ROW_W = BLK_W + PPB_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [BLK_W-1:0] blk_i,
    input  logic [PPB_W-1:0] ppb_i,
    input  logic [PPB_W-1:0] mark_page_i,
    input  logic [COL_W-1:0] mark_pos_i,
    output logic             req_valid_o,
    input  logic             req_ready_i,
    output logic [ROW_W-1:0] req_page_o,
    output logic [COL_W-1:0] req_col_o,
    input  logic             rsp_valid_i,
    input  logic [7:0]       rsp_data_i,
    output logic             busy_o,
    output logic             done_o,
    output logic             bad_o
);

    logic [BLK_W-1:0]  blk_q;
    logic [PPB_W-1:0]  ppb_q;
    logic [PPB_W-1:0]  mpage_q;
    logic [COL_W-1:0]  mpos_q;
    logic              four_q;
    logic [STEP_W-1:0] step_q;
    logic [PPB_W-1:0]  page_off;
    logic              last_step;

    badblk_ctrl #(.BLK_W(BLK_W), .PPB_W(PPB_W), .COL_W(COL_W)) i_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .blk_i       (blk_i),
        .ppb_i       (ppb_i),
        .mark_page_i (mark_page_i),
        .mark_pos_i  (mark_pos_i),
        .req_ready_i (req_ready_i),
        .rsp_valid_i (rsp_valid_i),
        .rsp_data_i  (rsp_data_i),
        .last_i      (last_step),
        .blk_o       (blk_q),
        .ppb_o       (ppb_q),
        .mark_page_o (mpage_q),
        .mark_pos_o  (mpos_q),
        .four_o      (four_q),
        .step_o      (step_q),
        .req_valid_o (req_valid_o),
        .busy_o      (busy_o),
        .done_o      (done_o),
        .bad_o       (bad_o)
    );

    badblk_plan #(.PPB_W(PPB_W), .COL_W(COL_W)) i_plan (
        .four_i      (four_q),
        .step_i      (step_q),
        .ppb_i       (ppb_q),
        .mark_page_i (mpage_q),
        .mark_pos_i  (mpos_q),
        .off_o       (page_off),
        .col_o       (req_col_o),
        .last_o      (last_step)
    );

    badblk_addr #(.BLK_W(BLK_W), .PPB_W(PPB_W)) i_addr (
        .blk_i (blk_q),
        .ppb_i (ppb_q),
        .off_i (page_off),
        .row_o (req_page_o)
    );

    // R9: a stalled request keeps its address
    assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_o && !req_ready_i |=> req_valid_o && $stable(req_page_o) && $stable(req_col_o));

    // R6: no request outside a scan
    assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !req_valid_o);

    // R2: four-page mode only touches spare bytes 0 and 1
    assert_quad_cols_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_o && four_q |-> req_col_o < COL_W'(2));

    // R4: requested row lies inside the captured block
    assert_row_in_block_R4: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_o && ppb_q != '0 |-> req_page_o / ROW_W'(ppb_q) == ROW_W'(blk_q));

endmodule

// File: tb/test_badblk_scan.sv
`timescale 1ns/1ps
module test_badblk_scan;

    localparam int BLK_W = 10;
    localparam int PPB_W = 8;
    localparam int COL_W = 8;
    localparam int ROW_W = BLK_W + PPB_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic [BLK_W-1:0] blk_i = '0;
    logic [PPB_W-1:0] ppb_i = '0;
    logic [PPB_W-1:0] mark_page_i = '0;
    logic [COL_W-1:0] mark_pos_i = '0;
    logic             req_valid_o;
    logic             req_ready_i = 1'b0;
    logic [ROW_W-1:0] req_page_o;
    logic [COL_W-1:0] req_col_o;
    logic             rsp_valid_i = 1'b0;
    logic [7:0]       rsp_data_i = 8'h00;
    logic             busy_o;
    logic             done_o;
    logic             bad_o;

    int errors = 0;
    int checks = 0;

    int log_page [0:15];
    int log_col  [0:15];
    int nlog  = 0;
    int ndone = 0;

    int       bad_en  = 0;
    int       bad_row = 0;
    int       bad_col = 0;
    logic [7:0] bad_val = 8'h00;

    always #2.5 clk = ~clk;

    badblk_scan #(.BLK_W(BLK_W), .PPB_W(PPB_W), .COL_W(COL_W)) i_badblk_scan (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .blk_i(blk_i), .ppb_i(ppb_i),
        .mark_page_i(mark_page_i), .mark_pos_i(mark_pos_i),
        .req_valid_o(req_valid_o), .req_ready_i(req_ready_i),
        .req_page_o(req_page_o), .req_col_o(req_col_o),
        .rsp_valid_i(rsp_valid_i), .rsp_data_i(rsp_data_i),
        .busy_o(busy_o), .done_o(done_o), .bad_o(bad_o)
    );

    function automatic logic [7:0] byte_of(input int row, input int col);
        if (bad_en != 0 && row == bad_row && col == bad_col) return bad_val;
        return 8'hFF;
    endfunction

    function automatic int quad_off(input int k, input int ppb);
        case (k / 2)
            0:       return 0;
            1:       return 1;
            2:       return ppb - 2;
            default: return ppb - 1;
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Device model: random ready, random response latency, logs accepted requests.
    initial begin : responder
        bit acc = 0;
        bit pending = 0;
        int lat = 0;
        int cap_row = 0;
        int cap_col = 0;
        forever begin
            @(negedge clk);
            rsp_valid_i = 1'b0;
            if (done_o) ndone++;
            if (acc) begin
                if (nlog < 16) begin
                    log_page[nlog] = cap_row;
                    log_col[nlog]  = cap_col;
                end
                nlog++;
                pending = 1;
                lat = int'($urandom % 3);
            end
            if (pending) begin
                if (lat == 0) begin
                    rsp_valid_i = 1'b1;
                    rsp_data_i  = byte_of(cap_row, cap_col);
                    pending = 0;
                end else begin
                    lat--;
                end
            end
            req_ready_i = ($urandom % 4) != 0;
            acc = req_valid_o && req_ready_i;
            if (acc) begin
                cap_row = int'(req_page_o);
                cap_col = int'(req_col_o);
            end
        end
    end

    task automatic run_op(input int blk, input int ppb, input int mp, input int mpos,
                          input int ben, input int boff, input int bcol, input bit poke);
        int four, n, ecount, ebad, t;
        int eoff [8];
        int ecol [8];
        four = (mp >= ppb) ? 1 : 0;
        n = four ? 8 : 1;
        for (int k = 0; k < n; k++) begin
            eoff[k] = four ? quad_off(k, ppb) : mp;
            ecol[k] = four ? (k % 2) : mpos;
        end
        bad_en  = ben;
        bad_row = blk * ppb + boff;
        bad_col = bcol;
        bad_val = 8'(($urandom % 255));
        ecount = n;
        ebad = 0;
        for (int k = 0; k < n; k++) begin
            if (ebad == 0 && byte_of(blk * ppb + eoff[k], ecol[k]) != 8'hFF) begin
                ecount = k + 1;
                ebad = 1;
            end
        end
        @(negedge clk);
        nlog = 0;
        ndone = 0;
        start_i = 1'b1;
        blk_i = BLK_W'(blk);
        ppb_i = PPB_W'(ppb);
        mark_page_i = PPB_W'(mp);
        mark_pos_i = COL_W'(mpos);
        @(negedge clk);
        start_i = 1'b0;
        if (poke) begin
            @(negedge clk);
            check(busy_o == 1'b1, "R7 busy before poke", int'(busy_o), 1);
            start_i = 1'b1;
            blk_i = BLK_W'(blk ^ 1);
            mark_page_i = '0;
            mark_pos_i = COL_W'(mpos + 3);
            @(negedge clk);
            start_i = 1'b0;
        end
        t = 0;
        while (ndone == 0 && t < 3000) begin
            @(negedge clk);
            t++;
        end
        repeat (4) @(negedge clk);
        check(t < 3000, "R5 scan finished", t, 0);
        check(ndone == 1, poke ? "R7 R8 done count" : "R8 done count", ndone, 1);
        check(bad_o == ebad[0], "R5 verdict", int'(bad_o), ebad);
        check(nlog == ecount, ebad ? "R6 early stop count" : "R1 request count", nlog, ecount);
        check(busy_o == 1'b0, "R8 idle after done", int'(busy_o), 0);
        for (int k = 0; k < ecount && k < nlog; k++) begin
            check(log_page[k] == blk * ppb + eoff[k], "R4 page address", log_page[k], blk * ppb + eoff[k]);
            check(log_col[k] == ecol[k], four ? "R2 column order" : "R3 mark column", log_col[k], ecol[k]);
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL R5 watchdog actual=%0d expected=%0d", 150000, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : stim
        void'($urandom(32'd20251));
        repeat (3) @(negedge clk);
        // R10: reset state
        check(busy_o == 1'b0, "R10 busy", int'(busy_o), 0);
        check(req_valid_o == 1'b0, "R10 req_valid", int'(req_valid_o), 0);
        check(done_o == 1'b0, "R10 done", int'(done_o), 0);
        check(bad_o == 1'b0, "R10 bad", int'(bad_o), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 R2: four-page good block, mark page exactly ppb
        run_op(5, 64, 64, 0, 0, 0, 0, 1'b0);
        // R1 R3: mark page ppb-1 stays single-byte
        run_op(7, 64, 63, 5, 0, 0, 0, 1'b0);
        // R3 R5: single-byte bad mark at the configured column
        run_op(9, 128, 10, 6, 1, 10, 6, 1'b0);
        // R5: bad byte at a neighbouring column is ignored in single-byte mode
        run_op(9, 128, 10, 6, 1, 10, 7, 1'b0);
        // R5: four-page mode ignores spare byte 2
        run_op(3, 32, 200, 0, 1, 0, 2, 1'b0);
        // R6: mismatch at each of the eight four-page positions
        for (int k = 0; k < 8; k++) begin
            run_op(100 + k, 16, 255, 0, 1, quad_off(k, 16), k % 2, 1'b0);
        end
        // R4: highest block and largest block size
        run_op(1023, 255, 255, 0, 0, 0, 0, 1'b0);
        run_op(1023, 255, 254, 0, 1, 254, 0, 1'b0);
        // R7: start while busy is ignored
        run_op(12, 32, 40, 0, 0, 0, 0, 1'b1);
        run_op(13, 32, 40, 0, 1, 31, 1, 1'b1);

        // random trials
        for (int i = 0; i < 60; i++) begin
            int ppb, mp, mpos, blk, ben, boff, bcol, k;
            ppb  = 4 + int'($urandom % 252);
            blk  = int'($urandom % 1024);
            mpos = int'($urandom % 64);
            ben  = int'($urandom % 2);
            if ($urandom % 2) begin
                mp   = ppb + int'($urandom % (256 - ppb));
                k    = int'($urandom % 8);
                boff = quad_off(k, ppb);
                bcol = ($urandom % 5 == 0) ? 2 : (k % 2);
            end else begin
                mp   = int'($urandom % ppb);
                boff = mp;
                bcol = ($urandom % 4 == 0) ? (mpos ^ 1) : mpos;
            end
            run_op(blk, ppb, mp, mpos, ben, boff, bcol, 1'b0);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule